// File: doc/BRIEF.md
# 4b/5b Receive Symbol Framer

This block sits behind the clock-recovery stage of a 4b/5b coded cell link. It takes one recovered bit per bit clock and finds where the 5-bit symbols begin. It then decodes each symbol into a data nibble or an escape indication. A small supervisor tracks link health and raises a good-signal status while the stream keeps decoding to legal codes. When the signal is lost, the supervisor forces the receive-FIFO enable low.

Alignment does not wait for an escape code. The transmitter sends only legal symbols, even when idle, so every illegal window at the candidate boundary shows that the boundary is wrong. On such a window the boundary moves by one bit, and the search goes on until a long enough run of legal symbols confirms the alignment. After lock, a sustained run of illegal symbols means the signal is gone, and the framer returns to the search.

Top module: `sym5_framer`

## Requirements
- R1: While `rst_i` is high at a clock edge, the framer enters the search state, with `sig_good_o`, `fifo_en_o`, `nib_valid_o` and `esc_o` all low. The first symbol after reset is taken from the next five bits.
- R2: Bits arrive first-bit-as-MSB. Legal data codes map as follows: 11110→0, 01001→1, 10100→2, 10101→3, 01010→4, 01011→5, 01110→6, 01111→7, 10010→8, 10011→9, 10110→A, 10111→B, 11010→C, 11011→D, 11100→E, 11101→F. While locked, a data code gives `nib_o` and a one-cycle `nib_valid_o` on the edge that samples its fifth bit.
- R3: Code 11000 is the escape. While locked, it raises `esc_o` for one cycle on the edge that samples its fifth bit, with no `nib_valid_o`. Every other 5-bit value is illegal.
- R4: When not locked, an illegal symbol at the candidate boundary moves the boundary one bit later, so the next symbol is tested six bits on. Alignment is reached on a stream of legal symbols that has no escape codes.
- R5: `sig_good_o` rises on the edge that completes the 16th consecutive legal symbol at one alignment. An illegal symbol before that restarts the search.
- R6: While locked, illegal symbols do not move the boundary. An illegal symbol produces no output pulse. A legal symbol clears the run of illegal symbols. The 8th consecutive illegal symbol drops `sig_good_o` on its edge and returns the framer to the search.
- R7: `fifo_en_o` is high exactly when `sig_good_o` is high, so it is forced low on loss of signal.
- R8: `nib_valid_o` and `esc_o` pulse only for symbols that complete after the lock edge, and each lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Recovered bit clock |
| rst_i | input | 1 | Synchronous active-high reset |
| rx_bit_i | input | 1 | Serial received bit |
| nib_o | output | 4 | Decoded data nibble |
| nib_valid_o | output | 1 | One-cycle strobe for `nib_o` |
| esc_o | output | 1 | One-cycle escape-code indication |
| sig_good_o | output | 1 | Good-signal status |
| fifo_en_o | output | 1 | Receive-FIFO enable |

## Verification
A wrong phase count or shift register shows at the ports within one symbol as nibbles that do not match the sent data, or as a boundary slip that delays `sig_good_o`. A miscounted lock run moves the rising edge of `sig_good_o` by whole symbols, so it shows five bit times early or late. A wrong loss counter either drops the status after fewer than eight bad symbols or keeps it after the eighth. Both are visible on the same edge where the run completes.

// File: rtl/sym5_framer.sv
module sym5_framer #(
  parameter int LOCK_RUN = 16,
  parameter int LOSS_RUN = 8
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       rx_bit_i,
  output logic [3:0] nib_o,
  output logic       nib_valid_o,
  output logic       esc_o,
  output logic       sig_good_o,
  output logic       fifo_en_o
);
  localparam int RW = $clog2(LOCK_RUN + 1);
  localparam int BW = $clog2(LOSS_RUN + 1);
  localparam logic [RW-1:0] RUN_LAST = RW'(LOCK_RUN - 1);
  localparam logic [BW-1:0] BAD_LAST = BW'(LOSS_RUN - 1);

  typedef enum logic [1:0] {ST_HUNT, ST_CONF, ST_LOCK} st_t;

  logic [3:0]    sr;
  logic [2:0]    ph;
  st_t           st;
  logic [RW-1:0] run;
  logic [BW-1:0] bad;

  function automatic logic [5:0] decode(input logic [4:0] s);
    case (s)
      5'b11110: decode = 6'b10_0000;
      5'b01001: decode = 6'b10_0001;
      5'b10100: decode = 6'b10_0010;
      5'b10101: decode = 6'b10_0011;
      5'b01010: decode = 6'b10_0100;
      5'b01011: decode = 6'b10_0101;
      5'b01110: decode = 6'b10_0110;
      5'b01111: decode = 6'b10_0111;
      5'b10010: decode = 6'b10_1000;
      5'b10011: decode = 6'b10_1001;
      5'b10110: decode = 6'b10_1010;
      5'b10111: decode = 6'b10_1011;
      5'b11010: decode = 6'b10_1100;
      5'b11011: decode = 6'b10_1101;
      5'b11100: decode = 6'b10_1110;
      5'b11101: decode = 6'b10_1111;
      5'b11000: decode = 6'b11_0000;
      default:  decode = 6'b00_0000;
    endcase
  endfunction

  wire [4:0] sym     = {sr, rx_bit_i};
  wire [5:0] dec     = decode(sym);
  wire       legal   = dec[5];
  wire       is_esc  = dec[4];
  wire       at_edge = (ph == 3'd0);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sr          <= '0;
      ph          <= 3'd4;
      st          <= ST_HUNT;
      run         <= '0;
      bad         <= '0;
      nib_o       <= '0;
      nib_valid_o <= 1'b0;
      esc_o       <= 1'b0;
      sig_good_o  <= 1'b0;
      fifo_en_o   <= 1'b0;
    end else begin
      sr          <= sym[3:0];
      nib_valid_o <= 1'b0;
      esc_o       <= 1'b0;
      if (!at_edge) begin
        ph <= ph - 3'd1;
      end else begin
        ph <= 3'd4;
        case (st)
          ST_HUNT:
            if (legal) begin
              st  <= ST_CONF;
              run <= RW'(1);
            end else begin
              ph <= 3'd5;
            end
          ST_CONF:
            if (!legal) begin
              st <= ST_HUNT;
              ph <= 3'd5;
            end else if (run == RUN_LAST) begin
              st         <= ST_LOCK;
              bad        <= '0;
              sig_good_o <= 1'b1;
              fifo_en_o  <= 1'b1;
            end else begin
              run <= run + RW'(1);
            end
          ST_LOCK:
            if (legal) begin
              bad <= '0;
              if (is_esc) esc_o <= 1'b1;
              else begin
                nib_valid_o <= 1'b1;
                nib_o       <= dec[3:0];
              end
            end else if (bad == BAD_LAST) begin
              st         <= ST_HUNT;
              bad        <= '0;
              sig_good_o <= 1'b0;
              fifo_en_o  <= 1'b0;
            end else begin
              bad <= bad + BW'(1);
            end
          default: st <= ST_HUNT;
        endcase
      end
    end
  end
endmodule

module sym5_framer_chk (
  input logic clk_i,
  input logic rst_i,
  input logic nib_valid_o,
  input logic esc_o,
  input logic sig_good_o,
  input logic fifo_en_o
);
  assert_reset_R1: assert property (@(posedge clk_i)
    $past(rst_i) |-> (!sig_good_o && !fifo_en_o && !nib_valid_o && !esc_o));

  assert_no_dual_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    !(nib_valid_o && esc_o));

  assert_fifo_follows_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    fifo_en_o == sig_good_o);

  assert_pulse_gated_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (nib_valid_o || esc_o) |-> sig_good_o);

  assert_one_cycle_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (nib_valid_o || esc_o) |=> !(nib_valid_o || esc_o));

  assert_loss_quiet_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(sig_good_o) |-> !nib_valid_o && !esc_o);
endmodule

bind sym5_framer sym5_framer_chk u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .nib_valid_o(nib_valid_o),
  .esc_o(esc_o), .sig_good_o(sig_good_o), .fifo_en_o(fifo_en_o)
);

// File: tb/sym5_framer_bench.sv
module sym5_framer_bench;
  logic clk = 1'b0, rst = 1'b0, din = 1'b0;
  logic [3:0] nib;
  logic valid, esc, good, fifo;
  int n_checks = 0, n_fail = 0;

  always #2 clk = ~clk;

  sym5_framer u_sym5_framer (
    .clk_i(clk), .rst_i(rst), .rx_bit_i(din), .nib_o(nib),
    .nib_valid_o(valid), .esc_o(esc), .sig_good_o(good), .fifo_en_o(fifo)
  );

  localparam logic [4:0] ESC = 5'b11000;
  localparam logic [4:0] BAD = 5'b00000;

  function automatic logic [4:0] enc(input int n);
    logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                           5'b01010, 5'b01011, 5'b01110, 5'b01111,
                           5'b10010, 5'b10011, 5'b10110, 5'b10111,
                           5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[n & 15];
  endfunction

  // model state: 0 hunt, 1 confirm, 2 locked
  int m_sr, m_ph, m_st, m_run, m_bad, e_nib;
  bit e_valid, e_esc, e_good;

  task automatic m_reset();
    m_sr = 0; m_ph = 4; m_st = 0; m_run = 0; m_bad = 0;
    e_valid = 0; e_esc = 0; e_good = 0; e_nib = 0;
  endtask

  task automatic m_update(input bit b);
    int s, code;
    bit leg, isesc;
    s = ((m_sr << 1) | b) & 31;
    m_sr = s & 15;
    e_valid = 0; e_esc = 0;
    if (m_ph != 0) begin m_ph--; return; end
    code = -1;
    for (int i = 0; i < 16; i++) if (enc(i) == 5'(s)) code = i;
    isesc = (5'(s) == ESC);
    leg = isesc || code >= 0;
    m_ph = 4;
    case (m_st)
      0: if (leg) begin m_st = 1; m_run = 1; end else m_ph = 5;
      1: if (!leg) begin m_st = 0; m_ph = 5; end
         else if (m_run == 15) begin m_st = 2; m_bad = 0; e_good = 1; end
         else m_run++;
      default:
         if (leg) begin
           m_bad = 0;
           if (isesc) e_esc = 1; else begin e_valid = 1; e_nib = code; end
         end else if (m_bad == 7) begin m_st = 0; m_bad = 0; e_good = 0; end
         else m_bad++;
    endcase
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R5 sig_good", good, e_good);
    chk("R7 fifo_en", fifo, e_good);
    chk("R8 nib_valid", valid, e_valid);
    chk("R3 esc", esc, e_esc);
    if (e_valid) chk("R2 nibble", nib, e_nib);
  endtask

  task automatic step(input bit b);
    din = b;
    @(posedge clk);
    m_update(b);
    @(negedge clk);
    compare();
  endtask

  task automatic send(input logic [4:0] s);
    for (int i = 4; i >= 0; i--) step(s[i]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; din = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
    m_reset();
    chk("R1 good", good, 0);
    chk("R1 fifo", fifo, 0);
    chk("R1 valid", valid, 0);
    chk("R1 esc", esc, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'h5EED1));
    do_reset();
    // R5: 15 legal symbols do not lock, the 16th does
    for (int i = 0; i < 15; i++) send(enc(i));
    chk("R5 no lock at 15", good, 0);
    send(enc(3));
    chk("R5 lock at 16", good, 1);
    for (int i = 0; i < 8; i++) send(enc(i * 5));
    send(ESC); send(enc(9));
    // R6: seven bad symbols keep lock, a legal one clears the run
    for (int i = 0; i < 7; i++) send(BAD);
    chk("R6 still good after 7", good, 1);
    send(enc(6));
    for (int i = 0; i < 7; i++) send(BAD);
    chk("R6 good after cleared run", good, 1);
    send(BAD);
    chk("R6 loss at 8th", good, 0);
    chk("R7 fifo off on loss", fifo, 0);
    // R5: broken run restarts search
    do_reset();
    for (int i = 0; i < 15; i++) send(enc(i));
    send(BAD);
    for (int i = 0; i < 15; i++) send(enc(i));
    chk("R5 broken run no lock", good, 0);
    // R4: misaligned start, cyclic legal stream
    do_reset();
    step(1); step(0); step(1);
    for (int i = 0; i < 64; i++) send(enc(i));
    chk("R4 aligned lock", good, 1);
    for (int i = 0; i < 16; i++) begin
      send(enc(i));
      chk("R4 aligned nibble", nib, i);
    end
    // random noise then random legal traffic
    do_reset();
    for (int i = 0; i < 400; i++) step(1'($urandom));
    for (int i = 0; i < 600; i++) begin
      int r = $urandom % 64;
      if (r == 0) send(5'($urandom));
      else if (r < 8) send(ESC);
      else send(enc($urandom % 16));
    end
    chk("R4 random traffic locked", good, 1);
    // reset in the middle of lock
    do_reset();
    for (int i = 0; i < 20; i++) send(enc($urandom % 16));
    summary();
  end
endmodule